// File: doc/BRIEF.md
# Machine-Cycle Timer / Event Counter

This block is a 16-bit up-counter that runs from the oscillator clock. The clock is grouped into machine cycles of 12 clocks. The count is held as a high byte and a low byte, and each byte can be loaded on its own. A source select picks what advances the count. In cycle mode the count steps once per machine cycle. In pin mode it steps on each high-to-low change of an external input, and that input is sampled only once per machine cycle.

Pin mode works from samples, not from the raw pin. A step needs one high sample followed by one low sample, and the new value appears at a fixed point of the machine cycle after the one in which the change was seen. The fastest input the block can follow therefore has a period of 24 clocks. A level held for less than one machine cycle may be missed. A sticky flag records every wrap from FFFFh to 0000h.

All pins are plain control and status levels. No data stream enters or leaves the block, so it has no valid/ready handshake and no back-pressure. A load is accepted in the clock where its strobe is high.

Top module: `mct_top`

## Requirements
- R1: After reset, `count` is 0000h and `ovf` is 0.
- R2: With `run_en`=1 and `src_pin`=0, `count` rises by exactly one every 12 clocks and by no other amount.
- R3: With `src_pin`=1, the pin is sampled once per 12-clock machine cycle. `count` rises by one for each pair of consecutive samples that reads 1 then 0. A pin held at a constant level never changes `count`.
- R4: In pin mode, the step caused by a pin fall becomes visible 8 to 19 clocks after the clock in which the pin fell. The sample point is clock 9 and the update point is clock 4 of the 12-clock cycle, counted from reset.
- R5: A pin that alternates between levels held for 12 clocks each is counted at every fall, which is one step per 24 clocks.
- R6: While `run_en`=0, `count` holds and pin falls are not counted. Sampling continues, so enabling the block with the pin already low creates no step.
- R7: `ld_hi` writes `hi_data` into bits 15:8 and `ld_lo` writes `lo_data` into bits 7:0, one clock after the strobe. In any clock with a load strobe, that load replaces the step that would have happened.
- R8: A step from FFFFh to 0000h sets `ovf`. `ovf` stays 1 until a clock with `ovf_clr`=1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_pin | input | 1 | External event input, sampled once per machine cycle |
| run_en | input | 1 | Run enable. When 0, the count holds |
| src_pin | input | 1 | Source select: 0 counts machine cycles, 1 counts pin falls |
| ld_hi | input | 1 | Load strobe for the high byte |
| hi_data | input | 8 | Value for the high byte |
| ld_lo | input | 1 | Load strobe for the low byte |
| lo_data | input | 8 | Value for the low byte |
| ovf_clr | input | 1 | Clears the wrap flag |
| count | output | 16 | Current count |
| ovf | output | 1 | Sticky wrap flag |

## Verification
The assertions assume that `cnt_pin` is already synchronous to `clk`. They also assume that the load strobes, `run_en` and `src_pin` are low or stable during reset. The bench meets both conditions by changing every input on the falling clock edge and by holding all inputs at 0 until reset is released. The pin-rate checks also assume that every pin level lasts at least one full machine cycle, so the bench changes the pin only at multiples of 12 clocks. The one exception is the disabled phase, where no step is expected at all.

// File: rtl/mct_pkg.sv
package mct_pkg;
  // Timing of the machine cycle
  localparam int unsigned CYC_LEN   = 12;
  localparam int unsigned SMP_PHASE = 9;  // clock of the cycle at which the pin is sampled
  localparam int unsigned UPD_PHASE = 4;  // clock of the cycle at which a pending step is applied

  typedef enum logic {
    SRC_CYCLE = 1'b0,
    SRC_PIN   = 1'b1
  } src_e;
endpackage

// File: rtl/mct_phase.sv
module mct_phase #(
  parameter int unsigned CYC_LEN   = 12,
  parameter int unsigned SMP_PHASE = 9,
  parameter int unsigned UPD_PHASE = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic smp_stb,
  output logic upd_stb
);
  localparam int unsigned PW = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
  localparam logic [PW-1:0] LAST = PW'(CYC_LEN - 1);
  localparam logic [PW-1:0] SPH  = PW'(SMP_PHASE);
  localparam logic [PW-1:0] UPH  = PW'(UPD_PHASE);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                      phase_q <= phase_q + 1'b1;
  end

  assign smp_stb = (phase_q == SPH);
  assign upd_stb = (phase_q == UPH);

  // The sample and update strobes are never high in the same clock (R4).
  p_strobe_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_stb && upd_stb));
endmodule

// File: rtl/mct_edge.sv
module mct_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_stb,
  input  logic upd_stb,
  input  logic pin,
  input  logic run_en,
  output logic edge_due
);
  logic smp_q;   // most recent sample of the pin
  logic pend_q;  // a fall has been seen and waits for the next update point

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (smp_stb) begin
        smp_q <= pin;  // the sample history updates even while the block is disabled
        if (run_en && smp_q && !pin) pend_q <= 1'b1;
      end else if (upd_stb) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign edge_due = pend_q && upd_stb;

  // A pending step appears only after a high sample followed by a low sample (R3).
  p_fall_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> (!smp_q && $past(smp_q)));
  // No pending step is raised while the block is disabled (R6).
  p_no_arm_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(run_en));
endmodule

// File: rtl/mct_count.sv
module mct_count #(
  parameter int unsigned WIDTH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        step,
  input  logic [1:0]                  ld,
  input  logic [1:0][WIDTH/2-1:0]     ld_data,
  input  logic                        ovf_clr,
  output logic [WIDTH-1:0]            count,
  output logic                        ovf
);
  localparam int unsigned BW = WIDTH / 2;

  logic              ld_any;
  logic [WIDTH-1:0]  next_val;
  logic              wrap;

  assign ld_any   = |ld;
  assign next_val = count + WIDTH'(1);
  assign wrap     = step && !ld_any && (count == {WIDTH{1'b1}});

  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        count[g*BW +: BW] <= '0;
      else if (ld[g])    count[g*BW +: BW] <= ld_data[g];
      else if (ld_any)   count[g*BW +: BW] <= count[g*BW +: BW];
      else if (step)     count[g*BW +: BW] <= next_val[g*BW +: BW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf <= 1'b0;
    else if (wrap)    ovf <= 1'b1;
    else if (ovf_clr) ovf <= 1'b0;
  end

  // Without a load, the count either holds or rises by exactly one (R2).
  p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ld_any) && (count != $past(count))) |-> (count == $past(count) + WIDTH'(1)));
  // A low-byte load takes effect in the next clock (R7).
  p_load_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld[0]) |-> (count[BW-1:0] == $past(ld_data[0])));
  // The flag rises only together with a wrap to zero (R8).
  p_wrap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> (count == '0));
  // The flag stays set until it is cleared (R8).
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ovf) && !$past(ovf_clr)) |-> ovf);
endmodule

// File: rtl/mct_top.sv
module mct_top #(
  parameter int unsigned WIDTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_pin,
  input  logic               run_en,
  input  logic               src_pin,
  input  logic               ld_hi,
  input  logic [WIDTH/2-1:0] hi_data,
  input  logic               ld_lo,
  input  logic [WIDTH/2-1:0] lo_data,
  input  logic               ovf_clr,
  output logic [WIDTH-1:0]   count,
  output logic               ovf
);
  import mct_pkg::*;

  logic smp_stb, upd_stb, edge_due, step;
  src_e src;

  assign src = src_e'(src_pin);

  mct_phase #(
    .CYC_LEN(CYC_LEN), .SMP_PHASE(SMP_PHASE), .UPD_PHASE(UPD_PHASE)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .upd_stb(upd_stb)
  );

  mct_edge u_edge (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .upd_stb(upd_stb),
    .pin(cnt_pin), .run_en(run_en), .edge_due(edge_due)
  );

  always_comb begin
    step = 1'b0;
    if (run_en) begin
      case (src)
        SRC_CYCLE: step = upd_stb;
        SRC_PIN:   step = edge_due;
        default:   step = 1'b0;
      endcase
    end
  end

  mct_count #(.WIDTH(WIDTH)) u_count (
    .clk(clk), .rst_n(rst_n), .step(step),
    .ld({ld_hi, ld_lo}), .ld_data({hi_data, lo_data}),
    .ovf_clr(ovf_clr), .count(count), .ovf(ovf)
  );

  // With the block disabled and no load, the count holds (R6).
  p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(run_en) && !$past(ld_hi) && !$past(ld_lo)) |-> $stable(count));
endmodule

// File: tb/sim_mct_top.sv
module sim_mct_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_pin = 1'b0, run_en = 1'b0, src_pin = 1'b0;
  logic        ld_hi = 1'b0, ld_lo = 1'b0, ovf_clr = 1'b0;
  logic [7:0]  hi_data = '0, lo_data = '0;
  logic [15:0] count;
  logic        ovf;

  int checks = 0, errors = 0;
  int cyc = 0;
  logic [15:0] exp_q[$];
  logic [15:0] exp_last = '0;
  logic [15:0] last_seen = '0;
  bit   gap_mode = 0, had_chg = 0;
  int   last_chg_cyc = 0, chg_cyc = 0;

  always #2 clk = ~clk;  // 250 MHz

  mct_top u0 (
    .clk(clk), .rst_n(rst_n), .cnt_pin(cnt_pin), .run_en(run_en), .src_pin(src_pin),
    .ld_hi(ld_hi), .hi_data(hi_data), .ld_lo(ld_lo), .lo_data(lo_data),
    .ovf_clr(ovf_clr), .count(count), .ovf(ovf)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] v);
    exp_q.push_back(v);
    exp_last = v;
  endtask

  task automatic push_steps(input int n);
    for (int i = 0; i < n; i++) push(exp_last + 16'd1);
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input string req);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  // Monitor: compares every change of count against the scoreboard
  always @(negedge clk) begin
    if (rst_n && count !== last_seen) begin
      chg_cyc = cyc;
      if (exp_q.size() == 0) begin
        chk(0, "R6/R3 unexpected change", count, last_seen);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(count === e, "R2/R3/R7 count value", count, e);
      end
      if (gap_mode && had_chg)
        chk(cyc - last_chg_cyc == 12, "R2 step spacing", cyc - last_chg_cyc, 12);
      had_chg = 1;
      last_chg_cyc = cyc;
      last_seen = count;
    end
  end

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    ticks(3);
    chk(count == 16'h0000, "R1 count after reset", count, 0);
    chk(ovf == 1'b0, "R1 ovf after reset", ovf, 0);
    rst_n = 1'b1;
    ticks(2);
    chk(count == 16'h0000, "R1 count idle", count, 0);

    // R2: cycle mode, 10 machine cycles
    gap_mode = 1; had_chg = 0;
    push_steps(10);
    run_en = 1; src_pin = 0;
    ticks(120);
    run_en = 0;
    ticks(2);
    gap_mode = 0;
    drain("R2 ten steps");

    // R6: disabled, pin toggles, nothing counts
    src_pin = 1;
    cnt_pin = 1; ticks(24);
    cnt_pin = 0; ticks(24);
    cnt_pin = 1; ticks(24);
    cnt_pin = 0; ticks(24);
    // enable with pin already low: no false step
    run_en = 1;
    ticks(48);
    chk(count == exp_last, "R6 no count while off or on re-enable", count, exp_last);

    // R3: pin held constant high in pin mode
    cnt_pin = 1;
    ticks(48);
    chk(count == exp_last, "R3 constant pin no step", count, exp_last);

    // R4: latency of one fall
    begin
      int t0;
      push_steps(1);
      cnt_pin = 0;
      t0 = cyc;
      had_chg = 0;
      ticks(30);
      chk(had_chg && (last_chg_cyc - t0) >= 8 && (last_chg_cyc - t0) <= 19,
          "R4 fall latency", last_chg_cyc - t0, 8);
      drain("R4 one step");
    end

    // R5: fastest rate, levels held 12 clocks
    push_steps(5);
    for (int i = 0; i < 5; i++) begin
      cnt_pin = 1; ticks(12);
      cnt_pin = 0; ticks(12);
    end
    ticks(24);
    drain("R5 five falls at max rate");

    // R3: cycle clocks are ignored in pin mode with pin low
    ticks(48);
    chk(count == exp_last, "R3 pin mode ignores cycles", count, exp_last);
    run_en = 0;

    // R7: byte loads
    push(16'h1234);
    ld_hi = 1; hi_data = 8'h12; ld_lo = 1; lo_data = 8'h34;
    ticks(1);
    ld_hi = 0; ld_lo = 0;
    ticks(2);
    chk(count == 16'h1234, "R7 both bytes loaded", count, 16'h1234);
    push(16'h12AB);
    ld_lo = 1; lo_data = 8'hAB;
    ticks(1);
    ld_lo = 0;
    ticks(2);
    chk(count == 16'h12AB, "R7 low byte only", count, 16'h12AB);

    // R7: load beats step while running in cycle mode
    src_pin = 0; run_en = 1;
    push(16'h1255);
    ld_lo = 1; lo_data = 8'h55;
    ticks(13);
    chk(count == 16'h1255, "R7 load priority over step", count, 16'h1255);
    ld_lo = 0;
    push_steps(2);
    ticks(24);
    run_en = 0;
    ticks(2);
    drain("R7 steps after load");

    // R8: wrap sets the flag
    push(16'hFFFE);
    ld_hi = 1; hi_data = 8'hFF; ld_lo = 1; lo_data = 8'hFE;
    ticks(1);
    ld_hi = 0; ld_lo = 0;
    ticks(1);
    chk(ovf == 1'b0, "R8 no flag before wrap", ovf, 0);
    push_steps(2);
    run_en = 1;
    ticks(24);
    run_en = 0;
    ticks(2);
    drain("R8 wrap steps");
    chk(count == 16'h0000, "R8 wrapped to zero", count, 0);
    chk(ovf == 1'b1, "R8 flag set", ovf, 1);
    ticks(30);
    chk(ovf == 1'b1, "R8 flag sticky", ovf, 1);
    ovf_clr = 1; ticks(1); ovf_clr = 0;
    ticks(1);
    chk(ovf == 1'b0, "R8 flag cleared", ovf, 0);

    ticks(5);
    drain("final scoreboard");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule